// File: doc/BRIEF.md
# Phased SPI Master Transaction Engine

This block is an SPI master that carries out one complete bus transaction for each start request, with chip select held low from start to finish. A transaction is made of up to four phases, always in the same order: an opcode, an address, outgoing data and incoming data. Each phase has its own enable and its own bit count. An optional guard interval of one SCLK period can be placed before the first clock edge, and another after the last one. Each guard has its own enable.

Before a transaction, the host sets the phase enables, the bit counts, the opcode word, the address word and the clock ratio. It also fills a bank of data words through a simple write port. It then pulses `start`. The engine shifts every phase out MSB first, stores incoming bits into the same bank, and pulses `done` as chip select is released. The host can read the bank back at any time through a read port. A typical use is a serial RAM: an 8-bit opcode, a 24-bit address left-aligned in the address word, and then a burst of data bytes.

Top module: `spi_phase_master`

## Requirements
- R1: During and after reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `done` is 0. Every bank word reads back as zero.
- R2: The enabled phases run in the order opcode, address, write data, read data. Each phase gives (bit count field + 1) rising SCLK edges, and a disabled phase gives none. `mosi` is 0 during the read-data phase.
- R3: The opcode phase sends `cmd_word` bits from index `cmd_bits_m1` down to index 0.
- R4: The address phase sends `addr_word` bits from index 31 downward, for `addr_bits_m1`+1 bits, so a short address is left-aligned.
- R5: The write-data phase sends bank word 0 first, then word 1, and so on. Within each word it sends bit 31 first, so bytes go out from the most significant byte down.
- R6: Read-data bit j is stored into bank word j/32 at bit 31-(j mod 32). Bank bits beyond the last received bit keep their earlier values.
- R7: Mode 0 timing applies. `mosi` changes only on a falling SCLK edge or outside SCLK activity, and it holds steady while `sclk` is high. `miso` is sampled at each rising SCLK edge.
- R8: Each SCLK half period lasts `half_div` system clocks, with 0 treated as 1, so successive rising edges are 2*`half_div` clocks apart.
- R9: With `en_setup` set, the first rising SCLK edge comes 3*`half_div` clocks after `cs_n` falls; with it clear, it comes after `half_div` clocks. With `en_hold` set, `cs_n` rises 2*`half_div` clocks after the last falling SCLK edge; with it clear, `cs_n` rises on that same edge.
- R10: `cs_n` stays low through the whole transaction, and each accepted start gives exactly one low pulse. `done` is high for exactly one clock, in the cycle in which `cs_n` returns high.
- R11: `busy` is 1 exactly while `cs_n` is low. A `start` received while busy has no effect.
- R12: A bank write through `ld_we` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| en_cmd | input | 1 | Enable opcode phase |
| en_addr | input | 1 | Enable address phase |
| en_wr | input | 1 | Enable write-data phase |
| en_rd | input | 1 | Enable read-data phase |
| en_setup | input | 1 | Add one SCLK period before the first edge |
| en_hold | input | 1 | Add one SCLK period after the last edge |
| cmd_bits_m1 | input | $clog2(CMD_W) | Opcode bit count minus one |
| addr_bits_m1 | input | $clog2(ADDR_W) | Address bit count minus one |
| wr_bits_m1 | input | $clog2(NWORDS*WW) | Write-data bit count minus one |
| rd_bits_m1 | input | $clog2(NWORDS*WW) | Read-data bit count minus one |
| cmd_word | input | CMD_W | Opcode value |
| addr_word | input | ADDR_W | Address, taken from the top end |
| half_div | input | DIV_W | System clocks per SCLK half period |
| ld_we | input | 1 | Bank word write strobe |
| ld_idx | input | $clog2(NWORDS) | Bank word to write |
| ld_data | input | WW | Bank word write value |
| rb_idx | input | $clog2(NWORDS) | Bank word to read |
| rb_data | output | WW | Bank word read value |
| miso | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse at the end of a transaction |

## Verification
The bench builds the engine with a four-word bank, an 8-bit opcode field, a 32-bit address and a 4-bit divider. With these values, a write or read that fills the whole bank (128 bits) finishes in a few hundred clocks, and that same transfer exercises every word boundary and the bank's last bit. The small opcode field lets odd opcode lengths such as 5 bits run. The 32-bit address field allows both a 24-bit left-aligned address and a full-width one. Divider values from 1 to 4 cover the tightest SCLK rate, where each half period is a single clock, and the spacing of the setup and hold guards.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

    // Phase numbering is also the running order of a transaction.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_CMD   = 3'd2,
        PH_ADDR  = 3'd3,
        PH_WR    = 3'd4,
        PH_RD    = 3'd5,
        PH_HOLD  = 3'd6
    } phase_e;

    localparam int PHASE_LAST = 6;

    function automatic logic is_shift(phase_e p);
        return (p == PH_CMD) || (p == PH_ADDR) || (p == PH_WR) || (p == PH_RD);
    endfunction

endpackage

// File: rtl/spi_pm_tick.sv
module spi_pm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             half_end
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim      = (half_div == '0) ? DIV_W'(1) : half_div;
        half_end = run && (cnt_q >= lim - DIV_W'(1));
        if (!run || half_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_pm_bank.sv
module spi_pm_bank #(
    parameter int NWORDS = 16,
    parameter int WW     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_we,
    input  logic [$clog2(NWORDS)-1:0]       host_widx,
    input  logic [WW-1:0]                   host_wdata,
    input  logic [$clog2(NWORDS)-1:0]       host_ridx,
    output logic [WW-1:0]                   host_rdata,
    input  logic                            eng_we,
    input  logic [$clog2(NWORDS*WW)-1:0]    eng_idx,
    input  logic                            eng_wbit,
    output logic                            eng_rbit
);

    localparam int POS_W = $clog2(WW);
    localparam int BIT_W = $clog2(NWORDS * WW);
    localparam int IDX_W = $clog2(NWORDS);

    logic [WW-1:0]    mem_q [NWORDS];
    logic [WW-1:0]    mem_d [NWORDS];
    logic [IDX_W-1:0] e_word;
    logic [POS_W-1:0] e_pos;

    // Stream bit k lives in word k/WW, counted from the top bit down.
    assign e_word = eng_idx[BIT_W-1:POS_W];
    assign e_pos  = ~eng_idx[POS_W-1:0];

    always_comb begin
        mem_d = mem_q;
        if (host_we) begin
            mem_d[host_widx] = host_wdata;
        end
        if (eng_we) begin
            mem_d[e_word][e_pos] = eng_wbit;
        end
    end

    assign host_rdata = mem_q[host_ridx];
    assign eng_rbit   = mem_q[e_word][e_pos];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
    import spi_pm_pkg::*;
#(
    parameter int NWORDS = 16,
    parameter int WW     = 32,
    parameter int CMD_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DIV_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          en_cmd,
    input  logic                          en_addr,
    input  logic                          en_wr,
    input  logic                          en_rd,
    input  logic                          en_setup,
    input  logic                          en_hold,
    input  logic [$clog2(CMD_W)-1:0]      cmd_bits_m1,
    input  logic [$clog2(ADDR_W)-1:0]     addr_bits_m1,
    input  logic [$clog2(NWORDS*WW)-1:0]  wr_bits_m1,
    input  logic [$clog2(NWORDS*WW)-1:0]  rd_bits_m1,
    input  logic [CMD_W-1:0]              cmd_word,
    input  logic [ADDR_W-1:0]             addr_word,
    input  logic [DIV_W-1:0]              half_div,
    input  logic                          ld_we,
    input  logic [$clog2(NWORDS)-1:0]     ld_idx,
    input  logic [WW-1:0]                 ld_data,
    input  logic [$clog2(NWORDS)-1:0]     rb_idx,
    output logic [WW-1:0]                 rb_data,
    input  logic                          miso,
    output logic                          sclk,
    output logic                          cs_n,
    output logic                          mosi,
    output logic                          busy,
    output logic                          done
);

    localparam int BIT_W   = $clog2(NWORDS * WW);
    localparam int CMD_LW  = $clog2(CMD_W);
    localparam int ADDR_LW = $clog2(ADDR_W);

    typedef struct packed {
        phase_e           phase;
        logic             hi;
        logic [BIT_W-1:0] bitn;
        logic             done;
    } state_t;

    state_t s_d, s_q;

    logic               run;
    logic               half_end;
    logic               eng_we;
    logic               eng_rbit;
    logic [6:0]         en_vec;
    phase_e             nxt;
    logic               found;
    logic [BIT_W-1:0]   len_m1;
    logic [CMD_LW-1:0]  cmd_idx;
    logic [ADDR_LW-1:0] addr_idx;

    assign run = (s_q.phase != PH_IDLE);

    spi_pm_tick #(.DIV_W(DIV_W)) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .half_end (half_end)
    );

    spi_pm_bank #(.NWORDS(NWORDS), .WW(WW)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (ld_we && !run),
        .host_widx  (ld_idx),
        .host_wdata (ld_data),
        .host_ridx  (rb_idx),
        .host_rdata (rb_data),
        .eng_we     (eng_we),
        .eng_idx    (s_q.bitn),
        .eng_wbit   (miso),
        .eng_rbit   (eng_rbit)
    );

    // Enable of each phase, indexed by its phase number.
    assign en_vec = {en_hold, en_rd, en_wr, en_addr, en_cmd, en_setup, 1'b0};

    // First enabled phase after the current one; idle when none is left.
    always_comb begin
        nxt   = PH_IDLE;
        found = 1'b0;
        for (int i = 1; i <= PHASE_LAST; i++) begin
            if (!found && (i > int'(s_q.phase)) && en_vec[i]) begin
                nxt   = phase_e'(3'(i));
                found = 1'b1;
            end
        end
    end

    // Length of the current phase in SCLK periods, minus one.
    always_comb begin
        case (s_q.phase)
            PH_CMD:  len_m1 = BIT_W'(cmd_bits_m1);
            PH_ADDR: len_m1 = BIT_W'(addr_bits_m1);
            PH_WR:   len_m1 = wr_bits_m1;
            PH_RD:   len_m1 = rd_bits_m1;
            default: len_m1 = '0;
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        eng_we   = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                s_d.phase = nxt;
                s_d.hi    = 1'b0;
                s_d.bitn  = '0;
                s_d.done  = (nxt == PH_IDLE);
            end
        end else if (half_end) begin
            if (!s_q.hi) begin
                // Rising half: capture read data here.
                s_d.hi = 1'b1;
                eng_we = (s_q.phase == PH_RD);
            end else begin
                // Falling half: step to the next bit or phase.
                s_d.hi = 1'b0;
                if (s_q.bitn == len_m1) begin
                    s_d.bitn  = '0;
                    s_d.phase = nxt;
                    s_d.done  = (nxt == PH_IDLE);
                end else begin
                    s_d.bitn = s_q.bitn + BIT_W'(1);
                end
            end
        end
    end

    assign cmd_idx  = cmd_bits_m1 - s_q.bitn[CMD_LW-1:0];
    assign addr_idx = ADDR_LW'(ADDR_W - 1) - s_q.bitn[ADDR_LW-1:0];

    always_comb begin
        case (s_q.phase)
            PH_CMD:  mosi = cmd_word[cmd_idx];
            PH_ADDR: mosi = addr_word[addr_idx];
            PH_WR:   mosi = eng_rbit;
            default: mosi = 1'b0;
        endcase
    end

    assign sclk = s_q.hi && is_shift(s_q.phase);
    assign cs_n = !run;
    assign busy = run;
    assign done = s_q.done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, hi: 1'b0, bitn: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/spi_phase_master_chk.sv
module spi_phase_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic done
);

    // R1: lines rest while chip select is inactive
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sclk && !mosi));

    // R7: data is steady through the high half of SCLK
    p_mosi_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R10: chip select release comes with the done pulse
    p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    // R10: done lasts one clock
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a chip select pulse only follows a start request
    p_cs_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start));

endmodule

bind spi_phase_master spi_phase_master_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi),
    .done  (done)
);

// File: tb/test_spi_phase_master.sv
`timescale 1ns/1ps
module test_spi_phase_master;

    localparam int NWORDS = 4;
    localparam int WW     = 32;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 32;
    localparam int DIV_W  = 4;

    typedef struct packed {
        logic       ec, ea, ew, er, es, eh;
        logic [2:0] cm1;
        logic [4:0] am1;
        logic [6:0] wm1, rm1;
        logic [3:0] div;
        logic [7:0] cmd;
        logic [31:0] addr;
        logic [7:0] seed;
        logic [8:0] exp_rises;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 3'd7,5'd23,7'd95, 7'd0,  4'd2, 8'h02,32'h12345600,8'h11,9'd128},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 3'd7,5'd23,7'd0,  7'd39, 4'd1, 8'h03,32'h00ABCD00,8'h22,9'd72},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 3'd0,5'd0, 7'd127,7'd0,  4'd3, 8'h00,32'h00000000,8'h33,9'd128},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 3'd0,5'd0, 7'd0,  7'd127,4'd1, 8'h00,32'h00000000,8'h44,9'd128},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 3'd4,5'd0, 7'd0,  7'd0,  4'd4, 8'h15,32'h00000000,8'h55,9'd6},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0,5'd31,7'd2,  7'd32, 4'd1, 8'h00,32'hDEADBEEF,8'h66,9'd68}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic start, en_cmd, en_addr, en_wr, en_rd, en_setup, en_hold;
    logic [2:0] cmd_bits_m1;
    logic [4:0] addr_bits_m1;
    logic [6:0] wr_bits_m1, rd_bits_m1;
    logic [7:0] cmd_word;
    logic [31:0] addr_word;
    logic [3:0] half_div;
    logic ld_we;
    logic [1:0] ld_idx, rb_idx;
    logic [31:0] ld_data, rb_data;
    logic miso;
    logic sclk, cs_n, mosi, busy, done;

    always #4 clk = ~clk;

    spi_phase_master #(.NWORDS(NWORDS), .WW(WW), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W))
    i_spi_phase_master (
        .clk(clk), .rst_n(rst_n), .start(start),
        .en_cmd(en_cmd), .en_addr(en_addr), .en_wr(en_wr), .en_rd(en_rd),
        .en_setup(en_setup), .en_hold(en_hold),
        .cmd_bits_m1(cmd_bits_m1), .addr_bits_m1(addr_bits_m1),
        .wr_bits_m1(wr_bits_m1), .rd_bits_m1(rd_bits_m1),
        .cmd_word(cmd_word), .addr_word(addr_word), .half_div(half_div),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .rb_idx(rb_idx), .rb_data(rb_data),
        .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done)
    );

    int errors = 0;
    int checks = 0;

    // Monitor state
    int   cyc = 0, rises = 0, cs_falls = 0, cs_rises = 0, done_cnt = 0, per_bad = 0, fidx = 0;
    int   t_csfall = 0, t_csrise = 0, t_first = 0, t_lastrise = 0, t_lastfall = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    logic mosi_log [256];
    logic [7:0] cur_seed = 8'h00;
    int   cur_div = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wv(input logic [7:0] seed, input int w);
        return ((32'(w) + 32'd1) * 32'h9E3779B9) ^ {4{seed}};
    endfunction

    function automatic logic pat_bit(input logic [7:0] seed, input int i);
        return (((i * 5) + (i / 4) + int'(seed)) % 3) == 1;
    endfunction

    // Target model and edge recorder, sampled 2 ns after each rising clock.
    initial begin
        miso = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (prev_cs && !cs_n) begin
                cs_falls++;
                t_csfall = cyc;
                fidx = 0;
                miso = pat_bit(cur_seed, 0);
            end
            if (!prev_cs && cs_n) begin
                cs_rises++;
                t_csrise = cyc;
            end
            if (!prev_sclk && sclk) begin
                if (rises < 256) mosi_log[rises] = mosi;
                if (rises == 0) t_first = cyc;
                else if ((cyc - t_lastrise) != 2 * cur_div) per_bad++;
                t_lastrise = cyc;
                rises++;
            end
            if (prev_sclk && !sclk) begin
                t_lastfall = cyc;
                fidx++;
                miso = pat_bit(cur_seed, fidx);
            end
            if (done) done_cnt++;
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic apply(input vec_t c);
        @(negedge clk);
        en_cmd = c.ec; en_addr = c.ea; en_wr = c.ew; en_rd = c.er;
        en_setup = c.es; en_hold = c.eh;
        cmd_bits_m1 = c.cm1; addr_bits_m1 = c.am1;
        wr_bits_m1 = c.wm1; rd_bits_m1 = c.rm1;
        cmd_word = c.cmd; addr_word = c.addr; half_div = c.div;
        cur_seed = c.seed;
        cur_div = (c.div == 0) ? 1 : int'(c.div);
    endtask

    task automatic load_words(input logic [7:0] seed);
        for (int w = 0; w < NWORDS; w++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_idx = 2'(w); ld_data = wv(seed, w);
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        rises = 0; cs_falls = 0; cs_rises = 0; done_cnt = 0; per_bad = 0;
    endtask

    task automatic start_pulse();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    function automatic int plen(input logic e, input int m1);
        return e ? m1 + 1 : 0;
    endfunction

    task automatic check_vector(input vec_t c, input int v);
        int lc, la, lw, lr, k, bad_c, bad_a, bad_w, bad_r;
        logic [31:0] expw, w;
        lc = plen(c.ec, int'(c.cm1));
        la = plen(c.ea, int'(c.am1));
        lw = plen(c.ew, int'(c.wm1));
        lr = plen(c.er, int'(c.rm1));
        bad_c = 0; bad_a = 0; bad_w = 0; bad_r = 0;
        chk(rises == int'(c.exp_rises), "R2", $sformatf("vec%0d rising edges", v), 64'(rises), 64'(c.exp_rises));
        for (int b = 0; b < lc + la + lw + lr; b++) begin
            if (b < lc) begin
                if (mosi_log[b] !== c.cmd[int'(c.cm1) - b]) bad_c++;
            end else if (b < lc + la) begin
                k = b - lc;
                if (mosi_log[b] !== c.addr[31 - k]) bad_a++;
            end else if (b < lc + la + lw) begin
                k = b - lc - la;
                w = wv(c.seed, k / 32);
                if (mosi_log[b] !== w[31 - (k % 32)]) bad_w++;
            end else begin
                if (mosi_log[b] !== 1'b0) bad_r++;
            end
        end
        chk(bad_c == 0, "R3", $sformatf("vec%0d opcode bit mismatches", v), 64'(bad_c), 64'd0);
        chk(bad_a == 0, "R4", $sformatf("vec%0d address bit mismatches", v), 64'(bad_a), 64'd0);
        chk(bad_w == 0, "R5", $sformatf("vec%0d write bit mismatches", v), 64'(bad_w), 64'd0);
        chk(bad_r == 0, "R2", $sformatf("vec%0d mosi high in read phase", v), 64'(bad_r), 64'd0);
        for (int wi = 0; wi < NWORDS; wi++) begin
            expw = wv(c.seed, wi);
            for (int j = 0; j < lr; j++) begin
                if (j / 32 == wi) expw[31 - (j % 32)] = pat_bit(c.seed, lc + la + lw + j);
            end
            @(negedge clk);
            rb_idx = 2'(wi);
            #1;
            chk(rb_data === expw, "R6 R7", $sformatf("vec%0d bank word %0d", v, wi), 64'(rb_data), 64'(expw));
        end
        chk(per_bad == 0, "R8", $sformatf("vec%0d SCLK period errors", v), 64'(per_bad), 64'd0);
        chk((t_first - t_csfall) == (c.es ? 3 : 1) * cur_div, "R9", $sformatf("vec%0d setup gap", v),
            64'(t_first - t_csfall), 64'((c.es ? 3 : 1) * cur_div));
        chk((t_csrise - t_lastfall) == (c.eh ? 2 * cur_div : 0), "R9", $sformatf("vec%0d hold gap", v),
            64'(t_csrise - t_lastfall), 64'(c.eh ? 2 * cur_div : 0));
        chk(cs_falls == 1 && cs_rises == 1 && done_cnt == 1, "R10", $sformatf("vec%0d cs pulses/done", v),
            64'(cs_falls * 100 + cs_rises * 10 + done_cnt), 64'd111);
    endtask

    initial begin
        bit ok;
        rst_n = 1'b0; start = 1'b0;
        en_cmd = 0; en_addr = 0; en_wr = 0; en_rd = 0; en_setup = 0; en_hold = 0;
        cmd_bits_m1 = '0; addr_bits_m1 = '0; wr_bits_m1 = '0; rd_bits_m1 = '0;
        cmd_word = '0; addr_word = '0; half_div = 4'd1;
        ld_we = 1'b0; ld_idx = '0; ld_data = '0; rb_idx = '0;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R1", "outputs in reset", 64'({cs_n, sclk, mosi, busy, done}), 64'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        rb_idx = 2'd2;
        #1;
        chk(rb_data === 32'h0, "R1", "bank word after reset", 64'(rb_data), 64'd0);
        chk(cs_n === 1'b1 && busy === 1'b0, "R1", "idle after reset", 64'({cs_n, busy}), 64'b10);

        // Table of transactions
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v]);
            load_words(VECS[v].seed);
            clear_mon();
            start_pulse();
            wait_done(ok);
            chk(ok, "R10", $sformatf("vec%0d done seen", v), 64'(ok), 64'd1);
            @(negedge clk);
            check_vector(VECS[v], v);
        end

        // Start while busy and bank write while busy are both ignored (R11, R12)
        apply(VECS[0]);
        load_words(8'h77);
        cur_seed = 8'h77;
        clear_mon();
        start_pulse();
        repeat (40) @(negedge clk);
        chk(busy === 1'b1 && cs_n === 1'b0, "R11", "busy while frame runs", 64'({busy, cs_n}), 64'b10);
        start = 1'b1;
        ld_we = 1'b1; ld_idx = 2'd3; ld_data = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0; ld_we = 1'b0;
        wait_done(ok);
        repeat (4) @(negedge clk);
        chk(cs_falls == 1 && rises == 128, "R11", "extra start ignored",
            64'(cs_falls * 1000 + rises), 64'(1128));
        rb_idx = 2'd3;
        #1;
        chk(rb_data === wv(8'h77, 3), "R12", "write while busy ignored", 64'(rb_data), 64'(wv(8'h77, 3)));

        // Two starts in a row give two pulses (R10)
        apply(VECS[4]);
        clear_mon();
        start_pulse();
        wait_done(ok);
        start_pulse();
        wait_done(ok);
        repeat (4) @(negedge clk);
        chk(cs_falls == 2 && cs_rises == 2 && done_cnt == 2, "R10", "back-to-back pulses",
            64'(cs_falls * 100 + cs_rises * 10 + done_cnt), 64'd222);
        chk(rises == 12, "R2", "back-to-back edge total", 64'(rises), 64'd12);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule